// File: doc/BRIEF.md
# BCD Timekeeper Register File

This block keeps calendar time (seconds, minutes, hours, day of week, date, month and a two-digit year) in a binary counter chain. The chain moves forward by one second on each pulse of a 1 Hz tick input. Software sees the time through eight byte-wide registers in BCD on a simple single-cycle bus. A write loads one field, but only when the value passes that field's range check. Bit 7 of the seconds register is a stop bit that freezes the chain. The control register forces some of its bits to fixed values.

Reads are registered: the data and a valid strobe appear one cycle after the request. Every bus request is taken in the cycle it is presented, and the bus has no back-pressure. A read of the seconds register also copies every time field into a snapshot. Reads of the other time registers return that snapshot. Software that reads seconds first and then the remaining fields therefore gets one consistent time, even if a tick arrives between two reads.

Top module: `bcd_tod_regfile`

## Requirements
- R1: Address map: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day/century, 5 date, 6 month, 7 year. A BCD byte decodes as (upper nibble × 10 + lower nibble). Writes to seconds or minutes decode the low 7 bits and take effect only if the result is 0 to 59; otherwise the field keeps its value.
- R2: An hours write decodes the low 6 bits and takes effect only for 0 to 23.
- R3: A date write decodes the low 6 bits and takes effect only for 1 to 31, so a zero result is ignored.
- R4: A month write decodes the low 5 bits and takes effect only for 1 to 12. A year write decodes all 8 bits and takes effect only for 0 to 99.
- R5: Every seconds write loads bit 7 as the stop bit, whether or not the seconds value is accepted. While the stop bit is set, ticks have no effect. Clearing it resumes counting from the frozen value. A seconds read returns the stop bit in bit 7 and the BCD seconds in bits 6:0.
- R6: In the day/century register, bits 2:0 are the day of week and bit 6 is a stored century flag. A read returns the century flag in bit 6, the day in bits 2:0, and zeros elsewhere.
- R7: A control write stores the value with bits 7 and 5 cleared and then bits 7 and 4 set. A control read returns the stored byte.
- R8: Each tick with the stop bit clear adds one second. The carry ripples from seconds into minutes, hours, date, month and year. The date wraps to 1 after 30 days in months 4, 6, 9 and 11, after 31 days in the other months, and after 29 days in February when the year is divisible by 4 (28 days otherwise). The year wraps from 99 to 0.
- R9: When the hours wrap past 23, the day of week advances by one. A day of 6 or 7 wraps to 0.
- R10: A seconds read copies every time field into a snapshot. Reads of addresses 2 to 7 return the snapshot, not the live count.
- R11: Read data and a one-cycle valid strobe appear in the cycle after a read request. The valid strobe is low after write cycles and idle cycles.
- R12: If a tick and a write fall in the same cycle, the tick is applied first, carries included. The written field then takes the written value.
- R13: After reset the block reads: time 00:00:00, day 0, date 01, month 01, year 00, control 0x00, stop bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Bus request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |

## Verification
Two functions can meet in one cycle: the per-second advance with its carry ripple, and a bus write that loads a field. The bench drives the tick and a write on the same clock edge in two cases. In the first, seconds are at 59 and the write targets seconds, so it must land on top of a carry into minutes. In the second, the write targets minutes while seconds step without a carry. The result is judged by reading seconds and then minutes through the snapshot. The expected values come from the rule that the tick is applied first and the write then overrides its field.

// File: rtl/bcd_tod_pkg.sv
package bcd_tod_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0, RA_SEC = 3'd1, RA_MIN = 3'd2, RA_HOUR = 3'd3,
    RA_DAY  = 3'd4, RA_DATE = 3'd5, RA_MON = 3'd6, RA_YEAR = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic       stop;
    logic       cent;
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] mon;
    logic [6:0] year;
  } tod_t;

  typedef struct packed {
    logic sec, min, hour, day, date, mon, year, stop;
  } upd_t;

  localparam tod_t TOD_RESET = '{stop: 1'b0, cent: 1'b0, sec: 6'd0, min: 6'd0,
                                 hour: 5'd0, dow: 3'd0, date: 5'd1, mon: 4'd1,
                                 year: 7'd0};

  function automatic logic [7:0] bcd_value(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [3:0] t;
    logic [3:0] o;
    t = 4'(v / 7'd10);
    o = 4'(v % 7'd10);
    return {t, o};
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic [1:0] ylo);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (ylo == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/tod_write_check.sv
module tod_write_check
  import bcd_tod_pkg::*;
(
  input  logic              wr_en,
  input  reg_addr_e         addr,
  input  logic [DATA_W-1:0] wdata,
  output upd_t              upd,
  output tod_t              val
);
  logic [7:0] dec7, dec6, dec5, dec8;

  always_comb begin
    dec7 = bcd_value({1'b0, wdata[6:0]});
    dec6 = bcd_value({2'b0, wdata[5:0]});
    dec5 = bcd_value({3'b0, wdata[4:0]});
    dec8 = bcd_value(wdata);
    val      = '0;
    val.stop = wdata[7];
    val.cent = wdata[6];
    val.sec  = dec7[5:0];
    val.min  = dec7[5:0];
    val.hour = dec6[4:0];
    val.dow  = wdata[2:0];
    val.date = dec6[4:0];
    val.mon  = dec5[3:0];
    val.year = dec8[6:0];
    upd = '0;
    if (wr_en) begin
      case (addr)
        RA_SEC: begin
          upd.stop = 1'b1;
          upd.sec  = (dec7 <= 8'd59);
        end
        RA_MIN:  upd.min  = (dec7 <= 8'd59);
        RA_HOUR: upd.hour = (dec6 <= 8'd23);
        RA_DAY:  upd.day  = 1'b1;
        RA_DATE: upd.date = (dec6 != 8'd0) && (dec6 <= 8'd31);
        RA_MON:  upd.mon  = (dec5 != 8'd0) && (dec5 <= 8'd12);
        RA_YEAR: upd.year = (dec8 <= 8'd99);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tod_chain.sv
module tod_chain
  import bcd_tod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  upd_t upd,
  input  tod_t val,
  output tod_t tod_q
);
  tod_t       nx;
  logic [4:0] dim;

  always_comb begin
    dim = month_days(tod_q.mon, tod_q.year[1:0]);
    nx  = tod_q;
    if (tick && !tod_q.stop) begin
      if (tod_q.sec != 6'd59) nx.sec = tod_q.sec + 6'd1;
      else begin
        nx.sec = 6'd0;
        if (tod_q.min != 6'd59) nx.min = tod_q.min + 6'd1;
        else begin
          nx.min = 6'd0;
          if (tod_q.hour != 5'd23) nx.hour = tod_q.hour + 5'd1;
          else begin
            nx.hour = 5'd0;
            nx.dow  = (tod_q.dow >= 3'd6) ? 3'd0 : tod_q.dow + 3'd1;
            if (tod_q.date < dim) nx.date = tod_q.date + 5'd1;
            else begin
              nx.date = 5'd1;
              if (tod_q.mon < 4'd12) nx.mon = tod_q.mon + 4'd1;
              else begin
                nx.mon  = 4'd1;
                nx.year = (tod_q.year >= 7'd99) ? 7'd0 : tod_q.year + 7'd1;
              end
            end
          end
        end
      end
    end
    if (upd.sec)  nx.sec  = val.sec;
    if (upd.min)  nx.min  = val.min;
    if (upd.hour) nx.hour = val.hour;
    if (upd.date) nx.date = val.date;
    if (upd.mon)  nx.mon  = val.mon;
    if (upd.year) nx.year = val.year;
    if (upd.stop) nx.stop = val.stop;
    if (upd.day) begin
      nx.dow  = val.dow;
      nx.cent = val.cent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tod_q <= TOD_RESET;
    else        tod_q <= nx;
  end

  // R5: a stopped chain with no write holds every field
  a_r5_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_q.stop && upd == '0) |=> $stable(tod_q));
  // R8: a tick without carry or write steps seconds by one
  a_r8_second_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tod_q.stop && upd == '0 && tod_q.sec != 6'd59)
      |=> (tod_q.sec == $past(tod_q.sec) + 6'd1));
  // R8: date and month stay inside their legal ranges
  a_r8_calendar_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_q.date != 5'd0 && tod_q.mon >= 4'd1 && tod_q.mon <= 4'd12));
  // R12: an accepted seconds write wins over the tick in the same cycle
  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    upd.sec |=> (tod_q.sec == $past(val.sec)));
endmodule

// File: rtl/tod_read_port.sv
module tod_read_port
  import bcd_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_addr_e         addr,
  input  tod_t              live,
  input  logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  tod_t              snap;
  logic [DATA_W-1:0] mux;
  logic [7:0]        sec_b, min_b, hour_b, date_b, mon_b, year_b;
  logic              unused_snap_bits;

  assign unused_snap_bits = ^{snap.stop, snap.sec};

  always_comb begin
    sec_b  = to_bcd({1'b0, live.sec});
    min_b  = to_bcd({1'b0, snap.min});
    hour_b = to_bcd({2'b0, snap.hour});
    date_b = to_bcd({2'b0, snap.date});
    mon_b  = to_bcd({3'b0, snap.mon});
    year_b = to_bcd(snap.year);
    case (addr)
      RA_CTRL: mux = ctrl;
      RA_SEC:  mux = sec_b | {live.stop, 7'b0};
      RA_MIN:  mux = min_b;
      RA_HOUR: mux = hour_b;
      RA_DAY:  mux = {1'b0, snap.cent, 3'b000, snap.dow};
      RA_DATE: mux = date_b;
      RA_MON:  mux = mon_b;
      default: mux = year_b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= TOD_RESET;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        rdata <= mux;
        if (addr == RA_SEC) snap <= live;
      end
    end
  end

  // R11: valid follows a read request by exactly one cycle
  a_r11_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r11_no_valid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
endmodule

// File: rtl/bcd_tod_regfile.sv
module bcd_tod_regfile
  import bcd_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam logic [DATA_W-1:0] CTRL_CLR = 8'hA0;
  localparam logic [DATA_W-1:0] CTRL_SET = 8'h90;

  reg_addr_e         addr;
  logic              wr_en, rd_en;
  upd_t              upd;
  tod_t              val, tod;
  logic [DATA_W-1:0] ctrl_q;

  assign addr  = reg_addr_e'(bus_addr);
  assign wr_en = bus_sel & bus_we;
  assign rd_en = bus_sel & ~bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && addr == RA_CTRL) ctrl_q <= (bus_wdata & ~CTRL_CLR) | CTRL_SET;
  end

  tod_write_check u_check (.wr_en(wr_en), .addr(addr), .wdata(bus_wdata), .upd(upd), .val(val));

  tod_chain u_chain (.clk(clk), .rst_n(rst_n), .tick(tick_1hz), .upd(upd), .val(val), .tod_q(tod));

  tod_read_port u_read (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .live(tod),
                        .ctrl(ctrl_q), .rdata(bus_rdata), .rvalid(bus_rvalid));

  // R7: a control write leaves bits 7 and 4 set and bit 5 clear
  a_r7_ctrl_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CTRL) |=> (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]));
  // R7: without a control write the control byte holds
  a_r7_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == RA_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/bcd_tod_regfile_tb_top.sv
`timescale 1ns/1ps
module bcd_tod_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  bcd_tod_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  // vector: {req, addr, write data, expected readback}
  localparam int NV = 23;
  localparam logic [22:0] VEC [NV] = '{
    {4'd1, 3'd2, 8'h45, 8'h45},  // R1 minutes accepted
    {4'd1, 3'd2, 8'h60, 8'h45},  // R1 minutes 60 ignored
    {4'd1, 3'd1, 8'h30, 8'h30},  // R1 seconds accepted
    {4'd1, 3'd1, 8'h5A, 8'h30},  // R1 seconds decode 60 ignored
    {4'd2, 3'd3, 8'h23, 8'h23},  // R2 hours 23
    {4'd2, 3'd3, 8'h24, 8'h23},  // R2 hours 24 ignored
    {4'd2, 3'd3, 8'hC5, 8'h05},  // R2 upper bits masked
    {4'd3, 3'd5, 8'h15, 8'h15},  // R3 date 15
    {4'd3, 3'd5, 8'h00, 8'h15},  // R3 date zero ignored
    {4'd3, 3'd5, 8'h32, 8'h15},  // R3 date 32 ignored
    {4'd3, 3'd5, 8'h31, 8'h31},  // R3 date 31
    {4'd4, 3'd6, 8'h12, 8'h12},  // R4 month 12
    {4'd4, 3'd6, 8'h13, 8'h12},  // R4 month 13 ignored
    {4'd4, 3'd6, 8'h00, 8'h12},  // R4 month 0 ignored
    {4'd4, 3'd7, 8'h99, 8'h99},  // R4 year 99
    {4'd4, 3'd7, 8'hA0, 8'h99},  // R4 year decode 100 ignored
    {4'd6, 3'd4, 8'h45, 8'h45},  // R6 century + day 5
    {4'd6, 3'd4, 8'hBF, 8'h07},  // R6 other bits dropped
    {4'd7, 3'd0, 8'hFF, 8'hDF},  // R7 control forced bits
    {4'd7, 3'd0, 8'h20, 8'h90},  // R7
    {4'd7, 3'd0, 8'h2A, 8'h9A},  // R7
    {4'd5, 3'd1, 8'h80, 8'h80},  // R5 stop bit set, seconds 0
    {4'd5, 3'd1, 8'h7F, 8'h00}   // R5 stop cleared though seconds rejected
  };

  task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic with_tick);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = with_tick;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; tick_1hz = 1'b0;
    chk(11, {7'd0, bus_rvalid}, 8'h00, "no valid after write");  // R11
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    chk(11, {7'd0, bus_rvalid}, 8'h01, "valid after read");  // R11
  endtask

  task automatic rd_chk(input int req, input logic [2:0] a, input logic [7:0] exp, input string what);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp, what);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic set_eod(input logic [7:0] y, input logic [7:0] m, input logic [7:0] dt);
    wr(3'd7, y, 1'b0); wr(3'd6, m, 1'b0); wr(3'd5, dt, 1'b0);
    wr(3'd3, 8'h23, 1'b0); wr(3'd2, 8'h59, 1'b0); wr(3'd1, 8'h59, 1'b0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    rd_chk(13, 3'd1, 8'h00, "reset seconds");
    rd_chk(13, 3'd2, 8'h00, "reset minutes");
    rd_chk(13, 3'd3, 8'h00, "reset hours");
    rd_chk(13, 3'd4, 8'h00, "reset day");
    rd_chk(13, 3'd5, 8'h01, "reset date");
    rd_chk(13, 3'd6, 8'h01, "reset month");
    rd_chk(13, 3'd7, 8'h00, "reset year");
    rd_chk(13, 3'd0, 8'h00, "reset control");
    @(negedge clk);
    chk(11, {7'd0, bus_rvalid}, 8'h00, "no valid when idle");

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      wr(v[18:16], v[15:8], 1'b0);
      rd(3'd1, d);
      rd_chk(int'(v[22:19]), v[18:16], v[7:0], $sformatf("vector %0d", i));
    end

    // R8 R9 full rollover at end of year
    set_eod(8'h99, 8'h12, 8'h31);
    wr(3'd4, 8'h06, 1'b0);
    pulse_tick();
    rd_chk(8, 3'd1, 8'h00, "new year seconds");
    rd_chk(8, 3'd2, 8'h00, "new year minutes");
    rd_chk(8, 3'd3, 8'h00, "new year hours");
    rd_chk(8, 3'd5, 8'h01, "new year date");
    rd_chk(8, 3'd6, 8'h01, "new year month");
    rd_chk(8, 3'd7, 8'h00, "year wrap 99 to 0");
    rd_chk(9, 3'd4, 8'h00, "day 6 wraps to 0");

    // R9 day 7 wraps to 0
    wr(3'd4, 8'h07, 1'b0);
    wr(3'd3, 8'h23, 1'b0); wr(3'd2, 8'h59, 1'b0); wr(3'd1, 8'h59, 1'b0);
    pulse_tick();
    rd(3'd1, d);
    rd_chk(9, 3'd4, 8'h00, "day 7 wraps to 0");

    // R8 leap February
    set_eod(8'h24, 8'h02, 8'h28);
    pulse_tick();
    rd(3'd1, d);
    rd_chk(8, 3'd5, 8'h29, "leap Feb 29");
    rd_chk(8, 3'd6, 8'h02, "leap still Feb");
    wr(3'd3, 8'h23, 1'b0); wr(3'd2, 8'h59, 1'b0); wr(3'd1, 8'h59, 1'b0);
    pulse_tick();
    rd(3'd1, d);
    rd_chk(8, 3'd5, 8'h01, "leap Mar 1 date");
    rd_chk(8, 3'd6, 8'h03, "leap Mar 1 month");

    // R8 non-leap February and 30-day month
    set_eod(8'h23, 8'h02, 8'h28);
    pulse_tick();
    rd(3'd1, d);
    rd_chk(8, 3'd5, 8'h01, "non-leap Feb end date");
    rd_chk(8, 3'd6, 8'h03, "non-leap Feb end month");
    set_eod(8'h23, 8'h04, 8'h30);
    pulse_tick();
    rd(3'd1, d);
    rd_chk(8, 3'd5, 8'h01, "April end date");
    rd_chk(8, 3'd6, 8'h05, "April end month");

    // R5 stop freezes, clearing resumes from frozen value
    wr(3'd1, 8'h92, 1'b0);
    repeat (3) pulse_tick();
    rd_chk(5, 3'd1, 8'h92, "frozen seconds");
    wr(3'd1, 8'h7F, 1'b0);
    rd_chk(5, 3'd1, 8'h12, "stop cleared, value kept");
    pulse_tick();
    rd_chk(5, 3'd1, 8'h13, "counting resumed");

    // R10 snapshot coherence
    wr(3'd2, 8'h10, 1'b0); wr(3'd1, 8'h59, 1'b0);
    rd_chk(10, 3'd1, 8'h59, "snapshot taken");
    pulse_tick();
    rd_chk(10, 3'd2, 8'h10, "minutes from snapshot");
    rd_chk(10, 3'd1, 8'h00, "live seconds");
    rd_chk(10, 3'd2, 8'h11, "refreshed minutes");

    // R12 tick and write in the same cycle
    wr(3'd1, 8'h59, 1'b0);
    wr(3'd1, 8'h30, 1'b1);
    rd_chk(12, 3'd1, 8'h30, "written seconds win");
    rd_chk(12, 3'd2, 8'h12, "carry still applied");
    wr(3'd2, 8'h40, 1'b1);
    rd_chk(12, 3'd1, 8'h31, "tick applied to seconds");
    rd_chk(12, 3'd2, 8'h40, "written minutes win");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule